// File: doc/BRIEF.md
# Extended-Precision NaN Screening Unit

This unit inspects one or two 80-bit extended-precision operands ahead of a floating-point operation. It decides two things: whether the operation must raise an invalid-operation exception, and which quiet NaN the operation should return when a NaN is present. Signaling and quiet NaNs are handled differently. An ordinary arithmetic operation traps only on a signaling NaN. Ordered compares, conversions to integer and conversions to packed decimal also trap on a quiet NaN. The unit never returns a signaling NaN. Arithmetic on non-NaN operands is left to the datapath behind it.

Each request enters on a valid/ready channel and its verdict leaves on a second valid/ready channel. The unit holds a single result register. `in_ready` is high when that register is empty or is being drained in the same cycle (`out_ready` high). A request is accepted on any rising edge where `in_valid` and `in_ready` are both high, and its verdict appears on the next edge. While `out_valid` is high and `out_ready` is low, the verdict holds unchanged and no new request is accepted. The operand and class inputs only need to be stable while `in_valid` is high.

Top module: `nan_screen`

## Requirements
- R1: An operand is a NaN when bits 78:64 are all ones, bit 63 (integer bit) is 1 and bits 62:0 are nonzero. Infinity (fraction zero) and an operand with integer bit 0 are not NaNs. `out_nan` is 1 when any examined operand is a NaN.
- R2: Bit 62 of a NaN is 1 for quiet and 0 for signaling. Every result with `out_nan` high has bits 78:64 all ones, bit 63 set and bit 62 set.
- R3: When `in_class` is 0 (arithmetic), `out_invalid` is 1 exactly when an examined operand is a signaling NaN. A quiet NaN gives no exception.
- R4: When `in_class` is 1 (ordered compare), 2 (store to integer) or 3 (store to packed decimal), `out_invalid` is 1 when any examined operand is a NaN, quiet or signaling.
- R5: When exactly one examined operand is a NaN, the result is that operand with bit 62 forced to 1. Its sign and all other bits are kept.
- R6: When both operands are NaNs, the result is built from the operand whose bits 63:0, read as an unsigned number, are larger. The first operand (`in_op_a`) wins a tie.
- R7: When `in_b_used` is 0, `in_op_b` is ignored and does not affect any of the outputs.
- R8: When no examined operand is a NaN, `out_invalid` and `out_nan` are 0 and `out_result` is all zeros.
- R9: A request accepted on an edge produces `out_valid` high with its verdict on the next edge.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the outputs hold their values.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| in_class | input | 2 | 0 arithmetic, 1 ordered compare, 2 store integer, 3 store decimal |
| in_b_used | input | 1 | Second operand takes part |
| in_op_a | input | 80 | First operand |
| in_op_b | input | 80 | Second operand |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Consumer takes the verdict |
| out_invalid | output | 1 | Invalid-operation exception required |
| out_nan | output | 1 | Result is a NaN |
| out_result | output | 80 | Quiet NaN to return, zero otherwise |

## Verification
Some properties are checked by assertions on every cycle. Every NaN leaving the unit is quiet and well formed. A verdict without a NaN carries no exception and a zero result. An accepted request always produces a verdict on the next edge. A stalled verdict does not move. The remaining behaviour can only be shown by the bench's scenarios, because it depends on the input values. This covers which class traps on which kind of NaN, which operand wins when both are NaNs (including a tie), whether the payload and sign survive quieting, and whether a disabled second operand is really ignored. The bench sweeps every pairing of eight operand kinds over all classes with the second operand both enabled and disabled.

// File: rtl/nan_screen_pkg.sv
package nan_screen_pkg;
  typedef enum logic [1:0] {
    OPC_ARITH   = 2'd0,
    OPC_CMP_ORD = 2'd1,
    OPC_TO_INT  = 2'd2,
    OPC_TO_DEC  = 2'd3
  } op_class_e;
endpackage

// File: rtl/nan_classify.sv
module nan_classify #(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W+MAN_W:0] opnd,
  input  logic                 enable,
  output logic                 is_nan,
  output logic                 is_snan
);
  localparam int FRAC_W = MAN_W - 1;
  localparam int QBIT   = FRAC_W - 1;

  logic exp_max, int_bit, frac_nz;

  always_comb begin
    exp_max = &opnd[EXP_W+MAN_W-1:MAN_W];
    int_bit = opnd[MAN_W-1];
    frac_nz = |opnd[FRAC_W-1:0];
    is_nan  = enable && exp_max && int_bit && frac_nz;
    is_snan = is_nan && !opnd[QBIT];
  end
endmodule

// File: rtl/nan_pick.sv
module nan_pick #(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W+MAN_W:0] op_a,
  input  logic [EXP_W+MAN_W:0] op_b,
  input  logic                 nan_a,
  input  logic                 nan_b,
  output logic [EXP_W+MAN_W:0] result
);
  localparam int W    = EXP_W + MAN_W + 1;
  localparam int QBIT = MAN_W - 2;

  logic          take_b;
  logic [W-1:0]  chosen;

  always_comb begin
    if (nan_a && nan_b)
      take_b = op_b[MAN_W-1:0] > op_a[MAN_W-1:0];
    else
      take_b = nan_b;
    chosen = take_b ? op_b : op_a;
    result = '0;
    if (nan_a || nan_b) begin
      result       = chosen;
      result[QBIT] = 1'b1;
    end
  end
endmodule

// File: rtl/nan_screen.sv
module nan_screen #(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [1:0]             in_class,
  input  logic                   in_b_used,
  input  logic [EXP_W+MAN_W:0]   in_op_a,
  input  logic [EXP_W+MAN_W:0]   in_op_b,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic                   out_invalid,
  output logic                   out_nan,
  output logic [EXP_W+MAN_W:0]   out_result
);
  import nan_screen_pkg::*;

  localparam int W      = EXP_W + MAN_W + 1;
  localparam int N_OPND = 2;
  localparam int QBIT   = MAN_W - 2;

  logic [W-1:0]      opnd [N_OPND];
  logic [N_OPND-1:0] opnd_en, nan_v, snan_v;
  logic [W-1:0]      res_d;
  logic              inv_d, nan_d, take;
  op_class_e         cls;

  assign opnd[0]    = in_op_a;
  assign opnd[1]    = in_op_b;
  assign opnd_en[0] = 1'b1;
  assign opnd_en[1] = in_b_used;

  for (genvar g = 0; g < N_OPND; g++) begin : g_cls
    nan_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .opnd   (opnd[g]),
      .enable (opnd_en[g]),
      .is_nan (nan_v[g]),
      .is_snan(snan_v[g])
    );
  end

  nan_pick #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pick (
    .op_a  (opnd[0]),
    .op_b  (opnd[1]),
    .nan_a (nan_v[0]),
    .nan_b (nan_v[1]),
    .result(res_d)
  );

  always_comb begin
    cls   = op_class_e'(in_class);
    nan_d = |nan_v;
    inv_d = (|snan_v) || ((cls != OPC_ARITH) && nan_d);
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_invalid <= 1'b0;
      out_nan     <= 1'b0;
      out_result  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (take) begin
        out_invalid <= inv_d;
        out_nan     <= nan_d;
        out_result  <= res_d;
      end
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
      && $stable(out_invalid) && $stable(out_nan))); // R10
  AST_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nan) |-> (out_result[QBIT] && out_result[MAN_W-1]
      && (&out_result[W-2:MAN_W]))); // R2
  AST_CLEAN_NUMBER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_nan) |-> (!out_invalid && out_result == '0)); // R8
endmodule

// File: tb/test_nan_screen.sv
`timescale 1ns/1ps
module test_nan_screen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_class = 2'd0;
  logic        in_b_used = 1'b0;
  logic [79:0] in_op_a = '0;
  logic [79:0] in_op_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_invalid;
  logic        out_nan;
  logic [79:0] out_result;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nan_screen i_nan_screen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_b_used(in_b_used), .in_op_a(in_op_a),
    .in_op_b(in_op_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_invalid(out_invalid), .out_nan(out_nan), .out_result(out_result)
  );

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [79:0] kind(input int k);
    case (k)
      0: return 80'h0;
      1: return {1'b0, 15'h3FFF, 1'b1, 63'h1234};
      2: return {1'b1, 15'h7FFF, 1'b1, 63'h0};
      3: return {1'b0, 15'h7FFF, 1'b1, 63'h4000_0000_0000_0ABC};
      4: return {1'b1, 15'h7FFF, 1'b1, 63'h0000_0000_0000_0055};
      5: return {1'b0, 15'h7FFF, 1'b1, 63'h3FFF_0000_0000_0001};
      6: return {1'b1, 15'h7FFF, 1'b1, 63'h4000_0000_0000_0ABC};
      default: return {1'b0, 15'h7FFF, 1'b0, 63'h4000_0000_0000_0001};
    endcase
  endfunction

  function automatic bit is_nan(input logic [79:0] x);
    return (x[78:64] == 15'h7FFF) && x[63] && (x[62:0] != 63'd0);
  endfunction

  task automatic run_one(input logic [79:0] a, input logic [79:0] b,
                         input int c, input bit u);
    bit na, nb, sa, sb, e_nan, e_inv;
    logic [79:0] e_res;
    string tag_inv, tag_res;
    na = is_nan(a);
    nb = u && is_nan(b);
    sa = na && !a[62];
    sb = nb && !b[62];
    e_nan = na || nb;
    e_inv = (c == 0) ? (sa || sb) : e_nan;
    if (na && nb) e_res = (b[63:0] > a[63:0]) ? (b | (80'd1 << 62)) : (a | (80'd1 << 62));
    else if (na) e_res = a | (80'd1 << 62);
    else if (nb) e_res = b | (80'd1 << 62);
    else e_res = '0;
    tag_inv = (c == 0) ? "R3" : "R4";
    if (!u && is_nan(b)) tag_res = "R7";
    else if (na && nb) tag_res = "R6";
    else if (e_nan) tag_res = "R5";
    else tag_res = "R8";
    @(negedge clk);
    in_valid = 1'b1; in_op_a = a; in_op_b = b; in_class = c[1:0]; in_b_used = u;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", {79'd0, out_valid}, 80'd1);
    chk("R1", {79'd0, out_nan}, {79'd0, e_nan});
    chk(tag_inv, {79'd0, out_invalid}, {79'd0, e_inv});
    chk(tag_res, out_result, e_res);
    if (e_nan) chk("R2", {79'd0, out_result[62]}, 80'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    chk("R11", {79'd0, out_valid}, 80'd0);
    chk("R11", {79'd0, in_ready}, 80'd1);

    // Sweep every operand-kind pairing, class and second-operand enable
    for (int ka = 0; ka < 8; ka++)
      for (int kb = 0; kb < 8; kb++)
        for (int c = 0; c < 4; c++)
          for (int u = 0; u < 2; u++)
            run_one(kind(ka), kind(kb), c, u[0]);

    // R10: back-pressure holds the verdict and blocks new requests
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op_a = kind(4); in_op_b = kind(0); in_class = 2'd0; in_b_used = 1'b0;
    @(negedge clk);
    chk("R10", {79'd0, in_ready}, 80'd0);
    in_op_a = kind(3); in_class = 2'd1;
    @(negedge clk);
    chk("R10", {79'd0, out_valid}, 80'd1);
    chk("R10", out_result, kind(4) | (80'd1 << 62));
    chk("R10", {79'd0, out_invalid}, 80'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", out_result, kind(3));
    chk("R4", {79'd0, out_invalid}, 80'd1);
    @(negedge clk);
    chk("R10", {79'd0, out_valid}, 80'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule